// File: doc/BRIEF.md
# Synchronous Burst Read Front-End

This block is the read path between a host bus and a word-wide memory array. It offers two read styles, chosen by a level on `mode`. With `mode` high, reads are asynchronous: the output word follows the address pins combinationally and is gated only by the enables. With `mode` low, reads are clocked bursts. The host loads a start address by holding `adv_n` low at a rising clock edge. It then advances an internal 17-bit word counter with `adv_n` high on later edges. Words come out of a short latency pipeline, one per clock once the burst is running.

The start latency depends on the parity of the loaded address. An odd start inserts one wait edge before the first array access, so its first word arrives one clock later than an even start. Bursts have no length limit and wrap around the full array. A new load in the middle of a burst discards the words still in flight. The array is modelled by a fixed, computed word pattern, so any bench can predict every word. The data bus is described as a driven value plus a drive-enable (`dq_oe`) for the pad ring. A `dq_valid` flag marks the cycles that carry a real word.

Top module: `brst_read_front`

## Requirements
- R1: With `mode` high, the block reads asynchronously. While the bus is driven, `dq_out` equals the array word at `addr` in the same cycle and `dq_valid` is 1. Clock edges do not load or advance the burst counter, whatever the level of `adv_n`. A burst suspended this way resumes at the next address once `mode` returns low.
- R2: An edge is active only when `ce_n`=0, `mode`=0 and `we_n`=1. At any other edge, `adv_n` and `addr` have no effect: the counter holds, a pending odd-start wait is kept, and no new word enters the pipeline.
- R3: At an active edge, `adv_n`=0 captures `addr` as the burst start. At an active edge, `adv_n`=1 advances the counter by one, so a burst presents the words at consecutive addresses.
- R4: For an even start (address bit 0 = 0), the first word is valid after the second rising edge that follows the load edge. For an odd start (bit 0 = 1), the first active edge after the load is a wait edge. It does not advance the counter whatever `adv_n` is, and the first word is valid after the third rising edge that follows the load edge.
- R5: A word requested by an increment edge is valid after the second rising edge that follows that edge. A steady burst therefore delivers one new word per clock.
- R6: An increment from address 0x1FFFF continues at 0x00000.
- R7: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, in both modes. When `dq_oe` is 0, `dq_valid` is 0.
- R8: A load edge discards every word still in flight. After the load edge, `dq_valid` stays 0 until the new burst's first word arrives with the latency of R4.
- R9: The array word at address a is the low 16 bits of a × 0x9E37, XORed with 0xA5A5 when bit 16 of a is 1.
- R10: While `rst_n` is low, and after it rises until the first word of a burst arrives, the synchronous path shows `dq_valid`=0. The counter restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output drive enable, active low |
| we_n | input | 1 | Write strobe, active low; low blocks reads and burst edges |
| mode | input | 1 | 0 selects clocked burst reads, 1 selects asynchronous reads |
| adv_n | input | 1 | At an active edge: 0 loads a start address, 1 advances the counter |
| addr | input | 17 | Word address |
| dq_out | output | 16 | Read data toward the pad |
| dq_oe | output | 1 | Pad drive enable; 0 means high impedance |
| dq_valid | output | 1 | The current `dq_out` carries a real array word |

## Verification
A counter that misses an advance or a wrap shows a wrong word on `dq_out` two clocks after the bad edge. Every later word in that burst then stays off by the same offset. A lost or spurious odd-start wait shifts the whole burst by one clock, so `dq_valid` rises one cycle early or late. A missed flush lets a stale word from the old burst appear in the cycle after the load edge. A wrong enable term shows on `dq_oe` in the very same cycle.

// File: rtl/brst_pkg.sv
package brst_pkg;

    parameter int unsigned BRST_ADDR_W = 17;
    parameter int unsigned BRST_DATA_W = 16;

    // Kind of action taken at one clock edge by the address sequencer
    typedef enum logic [1:0] {
        EDGE_IDLE = 2'd0,
        EDGE_LOAD = 2'd1,
        EDGE_WAIT = 2'd2,
        EDGE_STEP = 2'd3
    } edge_kind_e;

endpackage

// File: rtl/brst_array_model.sv
// Computed stand-in for the word array: a pure function of the address.
module brst_array_model #(
    parameter int unsigned          ADDR_W = brst_pkg::BRST_ADDR_W,
    parameter int unsigned          DATA_W = brst_pkg::BRST_DATA_W,
    parameter logic [DATA_W-1:0]    MUL    = 16'h9E37,
    parameter logic [DATA_W-1:0]    HI_XOR = 16'hA5A5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int unsigned PW = ADDR_W + DATA_W;

    logic [PW-1:0] prod;

    always_comb begin
        prod   = PW'(addr_i) * PW'(MUL);
        data_o = prod[DATA_W-1:0] ^ (addr_i[ADDR_W-1] ? HI_XOR : '0);
    end

endmodule

// File: rtl/brst_addr_seq.sv
// Burst address counter: load, odd-start wait edge, increment with wrap.
module brst_addr_seq
    import brst_pkg::*;
#(
    parameter int unsigned ADDR_W = BRST_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_act_i,
    input  logic              adv_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              req_v_o,
    output logic [ADDR_W-1:0] req_a_o,
    output logic              flush_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              pend;
    } seq_st_t;

    seq_st_t           st_q, st_d;
    edge_kind_e        kind;
    logic [ADDR_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        kind    = EDGE_IDLE;
        cnt_inc = st_q.cnt + ADDR_W'(1);
        if (edge_act_i) begin
            if (!adv_n_i) begin
                kind     = EDGE_LOAD;
                st_d.cnt = addr_i;
                st_d.pend = addr_i[0];
            end else if (st_q.pend) begin
                kind      = EDGE_WAIT;
                st_d.pend = 1'b0;
            end else begin
                kind     = EDGE_STEP;
                st_d.cnt = cnt_inc;
            end
        end
        flush_o = (kind == EDGE_LOAD);
        unique case (kind)
            EDGE_LOAD: begin
                req_v_o = !addr_i[0];
                req_a_o = addr_i;
            end
            EDGE_WAIT: begin
                req_v_o = 1'b1;
                req_a_o = st_q.cnt;
            end
            EDGE_STEP: begin
                req_v_o = 1'b1;
                req_a_o = cnt_inc;
            end
            default: begin
                req_v_o = 1'b0;
                req_a_o = st_q.cnt;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_act_i && adv_n_i && !st_q.pend && (st_q.cnt == '1)) |=> (st_q.cnt == '0)); // R6
    AST_ODD_START_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_act_i && !adv_n_i && addr_i[0]) |=> (st_q.pend && !$past(req_v_o))); // R4
    AST_IDLE_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_act_i |=> ($stable(st_q.cnt) && $stable(st_q.pend))); // R2
    AST_WAIT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_act_i && adv_n_i && st_q.pend) |=> $stable(st_q.cnt)); // R4

endmodule

// File: rtl/brst_lat_pipe.sv
// Latency pipeline: address stage, array read stage, output stage.
module brst_lat_pipe #(
    parameter int unsigned ADDR_W = brst_pkg::BRST_ADDR_W,
    parameter int unsigned DATA_W = brst_pkg::BRST_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_v_i,
    input  logic [ADDR_W-1:0] req_a_i,
    input  logic              flush_i,
    output logic              out_v_o,
    output logic [DATA_W-1:0] out_d_o
);

    typedef struct packed {
        logic              s1_v;
        logic [ADDR_W-1:0] s1_a;
        logic              s2_v;
        logic [DATA_W-1:0] s2_d;
        logic              o_v;
        logic [DATA_W-1:0] o_d;
    } pipe_st_t;

    pipe_st_t          st_q, st_d;
    logic [DATA_W-1:0] rd_word;

    brst_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .addr_i (st_q.s1_a),
        .data_o (rd_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = req_v_i;
        if (req_v_i) st_d.s1_a = req_a_i;
        st_d.s2_v = st_q.s1_v && !flush_i;
        st_d.s2_d = rd_word;
        st_d.o_v  = st_q.s2_v && !flush_i;
        st_d.o_d  = st_q.s2_d;
        out_v_o   = st_q.o_v;
        out_d_o   = st_q.o_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!st_q.o_v && !st_q.s2_v)); // R8
    AST_WORD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o_v |-> $past(st_q.s2_v)); // R5
    AST_REQ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && !flush_i) |=> st_q.s2_v); // R5

endmodule

// File: rtl/brst_read_front.sv
// Top: mode select, enable gating and drive control around the burst path.
module brst_read_front
    import brst_pkg::*;
#(
    parameter int unsigned ADDR_W = BRST_ADDR_W,
    parameter int unsigned DATA_W = BRST_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              mode,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dq_valid
);

    logic              edge_act;
    logic              req_v;
    logic [ADDR_W-1:0] req_a;
    logic              flush;
    logic              burst_v;
    logic [DATA_W-1:0] burst_d;
    logic [DATA_W-1:0] async_d;

    assign edge_act = !ce_n && !mode && we_n;

    brst_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_act_i (edge_act),
        .adv_n_i    (adv_n),
        .addr_i     (addr),
        .req_v_o    (req_v),
        .req_a_o    (req_a),
        .flush_o    (flush)
    );

    brst_lat_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_v_i (req_v),
        .req_a_i (req_a),
        .flush_i (flush),
        .out_v_o (burst_v),
        .out_d_o (burst_d)
    );

    brst_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_async_rd (
        .addr_i (addr),
        .data_o (async_d)
    );

    always_comb begin
        dq_oe    = !ce_n && !oe_n && we_n;
        dq_valid = dq_oe && (mode || burst_v);
        if (!dq_oe)    dq_out = '0;
        else if (mode) dq_out = async_d;
        else           dq_out = burst_d;
    end

    AST_ASYNC_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (!req_v && !flush)); // R1
    AST_HIZ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> (!dq_oe && !dq_valid)); // R7
    AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe); // R7

endmodule

// File: tb/brst_read_front_bench.sv
module brst_read_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, mode = 1'b0, adv_n = 1'b1;
    logic [16:0] addr = '0;
    logic [15:0] dq_out;
    logic        dq_oe, dq_valid;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [16:0] m_cnt;
    logic        m_pend;
    logic        sch1_v, sch2_v, vis_v;
    logic [16:0] sch1_a, sch2_a, vis_a;

    always #10 clk = ~clk;

    brst_read_front u_brst_read_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .mode(mode), .adv_n(adv_n), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid)
    );

    function automatic logic [15:0] ref_word(input logic [16:0] a);
        logic [32:0] p;
        p = {16'd0, a} * 33'h9E37;
        return p[15:0] ^ (a[16] ? 16'hA5A5 : 16'h0000);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_pend = 1'b0;
        sch1_v = 1'b0; sch2_v = 1'b0; vis_v = 1'b0;
        sch1_a = '0; sch2_a = '0; vis_a = '0;
    endtask

    // one rising edge of the requirement model (R2..R6, R8)
    task automatic model_edge();
        logic        iss_v;
        logic [16:0] iss_a;
        logic        act;
        iss_v = 1'b0; iss_a = '0;
        act = !ce_n && !mode && we_n;
        if (!rst_n) begin
            model_reset();
        end else begin
            vis_v = sch1_v; vis_a = sch1_a;
            sch1_v = sch2_v; sch1_a = sch2_a;
            if (act && !adv_n) begin
                vis_v = 1'b0; sch1_v = 1'b0;
                m_cnt = addr; m_pend = addr[0];
                if (!addr[0]) begin iss_v = 1'b1; iss_a = addr; end
            end else if (act && m_pend) begin
                m_pend = 1'b0; iss_v = 1'b1; iss_a = m_cnt;
            end else if (act) begin
                m_cnt = m_cnt + 17'd1; iss_v = 1'b1; iss_a = m_cnt;
            end
            sch2_v = iss_v; sch2_a = iss_a;
        end
    endtask

    task automatic compare(input string tag);
        logic exp_oe, exp_v;
        exp_oe = !ce_n && !oe_n && we_n;
        exp_v  = exp_oe && (mode || vis_v);
        chk({tag, " dq_oe"}, 32'(dq_oe), 32'(exp_oe));
        chk({tag, " dq_valid"}, 32'(dq_valid), 32'(exp_v));
        if (exp_v && dq_valid)
            chk({tag, " dq_out"}, 32'(dq_out), 32'(mode ? ref_word(addr) : ref_word(vis_a)));
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drv(input logic c, input logic o, input logic w, input logic m,
                       input logic a, input logic [16:0] ad);
        ce_n = c; oe_n = o; we_n = w; mode = m; adv_n = a; addr = ad;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5EED);
        model_reset();
        // R10: reset state
        drv(0, 0, 1, 0, 1, 17'd0);
        cyc("R10"); cyc("R10");
        @(negedge clk); rst_n = 1'b1;
        cyc("R10"); cyc("R10");

        // R4 even start, R5 steady burst
        drv(0, 0, 1, 0, 0, 17'h00010); cyc("R4");
        adv_n = 1'b1; addr = 17'h0BEEF;
        for (int i = 0; i < 6; i++) cyc("R5");

        // R4 odd start: wait edge with adv high
        drv(0, 0, 1, 0, 0, 17'h00033); cyc("R4");
        adv_n = 1'b1;
        for (int i = 0; i < 6; i++) cyc("R4");

        // R8 reload in the middle of a burst
        drv(0, 0, 1, 0, 0, 17'h01200); cyc("R8");
        adv_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R8");
        adv_n = 1'b0; addr = 17'h00501; cyc("R8");
        adv_n = 1'b1;
        for (int i = 0; i < 5; i++) cyc("R8");

        // R6 wrap from the top of the array
        drv(0, 0, 1, 0, 0, 17'h1FFFD); cyc("R6");
        adv_n = 1'b1;
        for (int i = 0; i < 7; i++) cyc("R6");

        // R2 deselect and write edges do not advance
        ce_n = 1'b1; adv_n = 1'b0; addr = 17'h0AAAA;
        for (int i = 0; i < 3; i++) cyc("R2");
        ce_n = 1'b0; we_n = 1'b0;
        for (int i = 0; i < 2; i++) cyc("R2");
        we_n = 1'b1; adv_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc("R2");

        // R7 output enable gating in both modes
        oe_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R7");
        oe_n = 1'b0; mode = 1'b1; ce_n = 1'b1; cyc("R7");
        ce_n = 1'b0;

        // R1 async reads, clock and adv ignored, burst resumes after
        for (int i = 0; i < 6; i++) begin
            adv_n = i[0]; addr = 17'(i * 4099 + 7);
            cyc("R1");
        end
        mode = 1'b0; adv_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc("R1");

        // R9 array content at fixed points
        mode = 1'b1;
        addr = 17'h00000; #1; chk("R9 word0", 32'(dq_out), 32'h0000);
        addr = 17'h00001; #1; chk("R9 word1", 32'(dq_out), 32'h9E37);
        addr = 17'h10000; #1; chk("R9 word10000", 32'(dq_out), 32'hA5A5);
        addr = 17'h00002; #1; chk("R9 word2", 32'(dq_out), 32'h3C6E);
        mode = 1'b0;

        // R3 random traffic
        for (int i = 0; i < 4000; i++) begin
            r = $urandom();
            ce_n  = (r[3:0] == 4'd0);
            oe_n  = (r[7:4] == 4'd1);
            we_n  = (r[12:8] != 5'd3);
            mode  = (r[17:13] == 5'd5);
            adv_n = (r[21:18] > 4'd1);
            addr  = r[22] ? {12'hFFF, r[27:23]} : 17'($urandom());
            cyc("R3");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule